// File: doc/BRIEF.md
# Cascadable CAM Slice with Match and Full Flags

This block is one slice of a content-addressable memory. It holds a fixed number of entries of a fixed data width, each with a valid bit. Single-cycle operations write a word into an entry and mark it valid, invalidate an entry, or compare a search key against every valid entry at once. After a compare the slice reports whether one entry matched, whether several matched, and the lowest-indexed matching entry. It also reports the lowest-indexed empty entry, which is the next free location.

Several slices stack vertically through two active-low chains. The match chain ranks the slices by priority. A slice whose incoming match line is low gives up its own match address to a slice higher in the chain. The full chain produces a memory-system-full indication. When a slice's full logic is disabled, the full chain passes straight through it. The device-level match flags reflect only this slice. They are cleared whenever the active register set select changes.

Top module: `cam_slice`

## Requirements
- R1: After reset all entries are empty, `match_n` and `multi_n` are high, `match_addr` is 0 and `free_addr` is 0.
- R2: Op code 2'b01 writes `op_data` into entry `op_addr` and marks it valid. Op code 2'b10 marks entry `op_addr` invalid. Op code 2'b00 does nothing. The new valid state shows on `free_addr` and `full_n` right after the clock edge.
- R3: Op code 2'b11 compares `op_data` with every valid entry. From the next edge, `match_n` is low exactly when at least one valid entry equals the key.
- R4: From the same edge, `multi_n` is low exactly when two or more valid entries equal the key.
- R5: `match_addr` is the lowest index of a matching valid entry, or 0 if none matched. `match_n` and `multi_n` do not depend on `casc_match_in_n`.
- R6: The match flags and `match_addr` keep their values until the next compare or the next change of the register set select, even across writes and invalidates.
- R7: A clock edge at which `bank_sel` differs from its value at the previous edge drives `match_n` and `multi_n` high and sets `match_addr` to 0. This clear takes priority over a compare in the same cycle.
- R8: `casc_match_out_n` is low when `casc_match_in_n` is low or `match_n` is low. `match_addr_vld` is high only when `match_n` is low and `casc_match_in_n` is high.
- R9: With `full_en` high, `full_n` is low exactly when every entry is valid and `casc_full_in_n` is low.
- R10: With `full_en` low, `full_n` equals `casc_full_in_n`.
- R11: `free_addr` is the lowest index of an invalid entry, or 0 if there is none. `free_here` is high exactly when `casc_full_in_n` is low and `full_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_code | input | 2 | 00 idle, 01 write, 10 invalidate, 11 compare |
| op_addr | input | ADDR_W | Entry index for write and invalidate |
| op_data | input | DATA_W | Write data or search key |
| bank_sel | input | 1 | Active register set select; any change clears the match flags |
| full_en | input | 1 | Enables the local contribution to the full chain |
| casc_match_in_n | input | 1 | Match chain from the slice above (tie high on the first slice) |
| casc_full_in_n | input | 1 | Full chain from the slice above (tie low on the first slice) |
| match_n | output | 1 | Low when one or more valid entries matched |
| multi_n | output | 1 | Low when two or more valid entries matched |
| match_addr | output | ADDR_W | Lowest matching entry index |
| match_addr_vld | output | 1 | This slice owns the chain's match address |
| casc_match_out_n | output | 1 | Match chain to the slice below |
| full_n | output | 1 | Full chain to the slice below |
| free_addr | output | ADDR_W | Lowest empty entry index |
| free_here | output | 1 | This slice owns the chain's next free location |

## Verification
A corrupted valid bit shows up at once on `free_addr` and `full_n`. It also changes the outcome of the next compare, which shows one edge later on `match_n`, `multi_n` and `match_addr`. A flag register that fails to hold, or fails to clear on a register set change, shows at the edge after the offending cycle. The chain outputs are combinational, so a wrong gating term is visible in the same cycle that the chain inputs change.

// File: rtl/cam_pkg.sv
package cam_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'b00,
    OP_WRITE = 2'b01,
    OP_INVAL = 2'b10,
    OP_CMP   = 2'b11
  } cam_op_e;
endpackage

// File: rtl/cam_lowest.sv
module cam_lowest #(
  parameter int N      = 16,
  parameter int IDX_W  = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     vec,
  output logic [IDX_W-1:0] idx,
  output logic             found
);
  always_comb begin
    idx   = '0;
    found = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        idx   = IDX_W'(i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cam_store.sv
module cam_store #(
  parameter int ENTRIES = 16,
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               inv_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [DATA_W-1:0]  key,
  output logic [ENTRIES-1:0] vld_o,
  output logic [ENTRIES-1:0] hit_o
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic              sel;
    logic              vld_q, vld_d;
    logic [DATA_W-1:0] word_q;

    assign sel = (addr == ADDR_W'(g));

    always_comb begin
      vld_d = vld_q;
      if (sel && wr_en)  vld_d = 1'b1;
      if (sel && inv_en) vld_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q <= 1'b0;
      else        vld_q <= vld_d;
    end

    always_ff @(posedge clk) begin
      if (sel && wr_en) word_q <= wdata;
    end

    assign vld_o[g] = vld_q;
    assign hit_o[g] = vld_q && (word_q == key);
  end

  AST_WRITE_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld_o[$past(addr)]); // R2
  AST_INVAL_CLEARS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    inv_en |=> !vld_o[$past(addr)]); // R2
endmodule

// File: rtl/cam_flags.sv
module cam_flags #(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmp_en,
  input  logic               bank_sel,
  input  logic [ENTRIES-1:0] hit_vec,
  output logic               match_q,
  output logic               multi_q,
  output logic [ADDR_W-1:0]  addr_q
);
  logic              bank_q;
  logic              bank_chg;
  logic              any_hit, many_hit;
  logic [ADDR_W-1:0] hit_idx;
  logic              match_d, multi_d;
  logic [ADDR_W-1:0] addr_d;
  logic              flag_en;

  cam_lowest #(.N(ENTRIES), .IDX_W(ADDR_W)) u_hit_enc (
    .vec   (hit_vec),
    .idx   (hit_idx),
    .found (any_hit)
  );

  assign many_hit = |(hit_vec & (hit_vec - ENTRIES'(1)));
  assign bank_chg = (bank_sel != bank_q);
  assign flag_en  = bank_chg || cmp_en;

  always_comb begin
    match_d = match_q;
    multi_d = multi_q;
    addr_d  = addr_q;
    if (bank_chg) begin
      match_d = 1'b0;
      multi_d = 1'b0;
      addr_d  = '0;
    end else if (cmp_en) begin
      match_d = any_hit;
      multi_d = many_hit;
      addr_d  = hit_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= 1'b0;
    end else begin
      bank_q <= bank_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= 1'b0;
      multi_q <= 1'b0;
      addr_q  <= '0;
    end else if (flag_en) begin
      match_q <= match_d;
      multi_q <= multi_d;
      addr_q  <= addr_d;
    end
  end

  AST_MULTI_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    multi_q |-> match_q); // R4
  AST_BANK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    bank_chg |=> (!match_q && !multi_q)); // R7
  AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_en && !bank_chg) |=> ($stable(match_q) && $stable(multi_q) && $stable(addr_q))); // R6
endmodule

// File: rtl/cam_slice.sv
module cam_slice #(
  parameter int ENTRIES = 16,
  parameter int DATA_W  = 16,
  localparam int ADDR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        op_code,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [DATA_W-1:0] op_data,
  input  logic              bank_sel,
  input  logic              full_en,
  input  logic              casc_match_in_n,
  input  logic              casc_full_in_n,
  output logic              match_n,
  output logic              multi_n,
  output logic [ADDR_W-1:0] match_addr,
  output logic              match_addr_vld,
  output logic              casc_match_out_n,
  output logic              full_n,
  output logic [ADDR_W-1:0] free_addr,
  output logic              free_here
);
  import cam_pkg::*;

  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  cam_op_e            op;
  logic               wr_en, inv_en, cmp_en;
  logic [ENTRIES-1:0] vld_vec, hit_vec;
  logic               match_q, multi_q;
  logic               free_found;
  logic               local_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign op     = cam_op_e'(op_code);
  assign wr_en  = (op == OP_WRITE);
  assign inv_en = (op == OP_INVAL);
  assign cmp_en = (op == OP_CMP);

  cam_store #(.ENTRIES(ENTRIES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .wr_en  (wr_en),
    .inv_en (inv_en),
    .addr   (op_addr),
    .wdata  (op_data),
    .key    (op_data),
    .vld_o  (vld_vec),
    .hit_o  (hit_vec)
  );

  cam_flags #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_flags (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cmp_en   (cmp_en),
    .bank_sel (bank_sel),
    .hit_vec  (hit_vec),
    .match_q  (match_q),
    .multi_q  (multi_q),
    .addr_q   (match_addr)
  );

  cam_lowest #(.N(ENTRIES), .IDX_W(ADDR_W)) u_free_enc (
    .vec   (~vld_vec),
    .idx   (free_addr),
    .found (free_found)
  );

  assign local_full       = !free_found;
  assign match_n          = !match_q;
  assign multi_n          = !multi_q;
  assign match_addr_vld   = match_q && casc_match_in_n;
  assign casc_match_out_n = casc_match_in_n && match_n;
  assign full_n           = full_en ? !(local_full && !casc_full_in_n) : casc_full_in_n;
  assign free_here        = !casc_full_in_n && full_n;

  AST_FULL_NEEDS_CHAIN: assert property (@(posedge clk) disable iff (!rst_int_n)
    !full_n |-> !casc_full_in_n); // R9
  AST_FULL_NEEDS_NO_FREE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (full_en && !full_n) |-> (vld_vec == '1)); // R9
  AST_ADDR_VALID_QUAL: assert property (@(posedge clk) disable iff (!rst_int_n)
    match_addr_vld |-> (!match_n && casc_match_in_n)); // R8
  AST_CHAIN_OUT_LOW: assert property (@(posedge clk) disable iff (!rst_int_n)
    !match_n |-> !casc_match_out_n); // R8
endmodule

// File: tb/cam_slice_tb.sv
module cam_slice_tb;
  localparam int N  = 16;
  localparam int DW = 16;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    op_code;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_data;
  logic          bank_sel, full_en, casc_match_in_n, casc_full_in_n;
  logic          match_n, multi_n, match_addr_vld, casc_match_out_n, full_n, free_here;
  logic [AW-1:0] match_addr, free_addr;

  cam_slice #(.ENTRIES(N), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_code(op_code), .op_addr(op_addr), .op_data(op_data),
    .bank_sel(bank_sel), .full_en(full_en), .casc_match_in_n(casc_match_in_n),
    .casc_full_in_n(casc_full_in_n), .match_n(match_n), .multi_n(multi_n),
    .match_addr(match_addr), .match_addr_vld(match_addr_vld),
    .casc_match_out_n(casc_match_out_n), .full_n(full_n), .free_addr(free_addr),
    .free_here(free_here)
  );

  always #10 clk = ~clk;

  int    total = 0;
  int    bad   = 0;
  string phase = "R1";
  bit    done  = 0;

  int m_data[N];
  bit m_vld[N];
  bit m_match, m_multi, m_bank;
  int m_addr;

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s/%s %s actual=%0d expected=%0d", phase, req, what, act, exp);
    end
  endtask

  task automatic check_all();
    bit all_v = 1;
    int fr = 0;
    bit found = 0;
    bit exp_full_n;
    for (int i = 0; i < N; i++) begin
      if (!m_vld[i]) begin
        all_v = 0;
        if (!found) begin fr = i; found = 1; end
      end
    end
    exp_full_n = full_en ? !(all_v && !casc_full_in_n) : casc_full_in_n;
    chk("R3", "match_n", int'(match_n), int'(!m_match));
    chk("R4", "multi_n", int'(multi_n), int'(!m_multi));
    chk("R5", "match_addr", int'(match_addr), m_addr);
    chk("R8", "match_addr_vld", int'(match_addr_vld), int'(m_match && casc_match_in_n));
    chk("R8", "casc_match_out_n", int'(casc_match_out_n), int'(casc_match_in_n && !m_match));
    chk(full_en ? "R9" : "R10", "full_n", int'(full_n), int'(exp_full_n));
    chk("R11", "free_addr", int'(free_addr), fr);
    chk("R11", "free_here", int'(free_here), int'(!casc_full_in_n && exp_full_n));
  endtask

  // Model update for the edge just taken, using the inputs applied for that cycle.
  task automatic model_edge();
    int cnt = 0;
    int low = 0;
    if (bank_sel != m_bank) begin
      m_match = 0; m_multi = 0; m_addr = 0;
    end else if (op_code == 2'b11) begin
      for (int i = N - 1; i >= 0; i--)
        if (m_vld[i] && m_data[i] == int'(op_data)) begin cnt++; low = i; end
      m_match = (cnt >= 1);
      m_multi = (cnt >= 2);
      m_addr  = low;
    end
    m_bank = bank_sel;
    if (op_code == 2'b01) begin m_vld[op_addr] = 1; m_data[op_addr] = int'(op_data); end
    if (op_code == 2'b10) m_vld[op_addr] = 0;
  endtask

  task automatic cyc(logic [1:0] oc, int a, int d);
    op_code = oc; op_addr = AW'(a); op_data = DW'(d);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check_all();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; op_code = 0; op_addr = 0; op_data = 0;
    bank_sel = 0; full_en = 1; casc_match_in_n = 1; casc_full_in_n = 0;
    for (int i = 0; i < N; i++) begin m_vld[i] = 0; m_data[i] = 0; end
    m_match = 0; m_multi = 0; m_bank = 0; m_addr = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1: reset state, checked while the internal reset releases
    phase = "R1";
    check_all();
    for (int k = 0; k < 3; k++) cyc(2'b00, 0, 0);

    phase = "R2";
    cyc(2'b01, 3, 16'hAAAA);
    cyc(2'b01, 0, 16'h0001);
    cyc(2'b01, 5, 16'h1234);
    cyc(2'b01, 9, 16'hAAAA);
    cyc(2'b10, 0, 0);

    phase = "R3";
    cyc(2'b11, 0, 16'h1234);
    cyc(2'b11, 0, 16'h0001);
    phase = "R4";
    cyc(2'b11, 0, 16'hAAAA);
    phase = "R6";
    cyc(2'b01, 7, 16'h5555);
    cyc(2'b10, 9, 0);
    cyc(2'b00, 0, 0);
    phase = "R5";
    cyc(2'b11, 0, 16'hAAAA);
    cyc(2'b01, 2, 16'hAAAA);
    cyc(2'b11, 0, 16'hAAAA);
    casc_match_in_n = 0;
    cyc(2'b00, 0, 0);
    cyc(2'b11, 0, 16'h5555);
    casc_match_in_n = 1;
    cyc(2'b00, 0, 0);

    phase = "R7";
    bank_sel = 1;
    cyc(2'b00, 0, 0);
    cyc(2'b11, 0, 16'hAAAA);
    bank_sel = 0;
    cyc(2'b11, 0, 16'hAAAA);
    cyc(2'b11, 0, 16'h5555);

    phase = "R9";
    for (int i = 0; i < N; i++) cyc(2'b01, i, 16'h0100 + i);
    casc_full_in_n = 1;
    cyc(2'b00, 0, 0);
    casc_full_in_n = 0;
    cyc(2'b11, 0, 16'h0100 + 15);
    cyc(2'b10, 11, 0);
    cyc(2'b01, 11, 16'h0100);
    cyc(2'b11, 0, 16'h0100);

    phase = "R10";
    full_en = 0;
    cyc(2'b00, 0, 0);
    casc_full_in_n = 1;
    cyc(2'b00, 0, 0);
    cyc(2'b10, 4, 0);
    casc_full_in_n = 0;
    cyc(2'b00, 0, 0);

    phase = "R11";
    full_en = 1;
    cyc(2'b00, 0, 0);
    cyc(2'b10, 1, 0);
    cyc(2'b01, 4, 16'h7777);
    cyc(2'b01, 1, 16'h7777);
    cyc(2'b11, 0, 16'h7777);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule